// File: doc/BRIEF.md
# Fault Filter and Over-Current Retry Supervisor

This block sits between a set of raw protection comparators and the output-stage control of a multi-channel load driver. Each raw flag (per-channel over-current and open-load, supply under-voltage and over-voltage, temperature warning, thermal shutdown) must stay present for a minimum time before it counts. A free-running tick of one microsecond, divided from the system clock, times these filters. A flag that holds long enough is latched into one of two 16-bit status words, which the serial interface shifts out. The host clears all latched flags with a single clear pulse.

The block also decides when each channel must be forced off. Over-current switches its own channel off. Thermal shutdown, supply faults and the start-up period switch all channels off. Open-load and temperature warning only report. A channel with retry enabled does not wait for the host after an over-current: it switches itself on again after a pause. This gives a low duty pulse train (about one eighth or one quarter on) that can bring up loads with high inrush current. A summary no-error bit and a not-ready bit complete the status words. Pulling the enable input low returns everything to its cleared state.

Top module: `fault_supervisor`

## Requirements
- R1: A raw over-current, under-voltage, over-voltage, temperature-warning or thermal-shutdown flag sets its status bit only after it has been held for FAST_TICKS ticks. The bit appears between (FAST_TICKS-1)*TICK_DIV+2 and FAST_TICKS*TICK_DIV+1 clock cycles after the flag rises. For over-current the count runs only while that channel is switched on.
- R2: A raw open-load flag sets its status bit between (OL_TICKS-1)*TICK_DIV+2 and OL_TICKS*TICK_DIV+1 clock cycles after it rises.
- R3: A flag that drops before its filter time has run out leaves no status bit set. Its filter count restarts from zero, so separated short pulses never add up.
- R4: A latched over-current bit forces its channel off (drv_off high). If retry is disabled for that channel, the channel stays off after the raw flag has gone, until a clear pulse removes the bit. The other channels are not affected.
- R5: With retry enabled, a channel with a held over-current has a repeating pattern. It is on for FAST_TICKS ticks (plus at most one clock) and then off for 3*FAST_TICKS ticks when duty_hi=1, or for 7*FAST_TICKS ticks when duty_hi=0. The over-current status bit stays set throughout.
- R6: While the temperature-warning status bit is set, the retry pause is always the long one (7*FAST_TICKS), whatever duty_hi is.
- R7: A set thermal-shutdown bit forces all channels off. A clear pulse does not remove the bit while the raw thermal flag is still present. Once the raw flag is gone, a clear removes the bit and the channels come back.
- R8: A filtered supply fault switches all channels off. With uv_ov_latch=0, the channels return as soon as the raw flag drops. With uv_ov_latch=1, they stay off until a clear removes the latched bit. In both cases the latched bit stays set until a clear.
- R9: Open-load and temperature-warning bits never switch any channel off.
- R10: Status layout for NUM_DRV=5. stat0: bit 0 no-error, bits 1-5 over-current of channels 0-4, bit 6 under-voltage, bit 7 over-voltage, bit 8 temperature warning, bit 9 thermal shutdown, bit 15 not-ready. stat1: bit 0 no-error, bits 1-5 open-load of channels 0-4. All other bits read 0. No-error is 1 exactly when bits 1-14 of both words are 0; open-load bits are left out of this when ol_mask=1.
- R11: When en rises, not-ready reads 1 and all channels are off. Not-ready clears by itself between (STARTUP_TICKS-1)*TICK_DIV+1 and STARTUP_TICKS*TICK_DIV cycles later.
- R12: While en is low, all channels are off. One cycle after en goes low, every latched bit is 0, not-ready reads 1 and no-error reads 1 (stat0=16'h8001, stat1=16'h0001).
- R13: A fault that is still present when a clear pulse arrives keeps its status bit set: setting takes priority over clearing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Active-mode enable; low clears all state |
| clr_stat | input | 1 | One-cycle pulse clearing latched status |
| rec_en | input | NUM_DRV | Per-channel over-current retry enable |
| duty_hi | input | 1 | Retry duty select: 1 quarter, 0 eighth |
| uv_ov_latch | input | 1 | Supply faults keep channels off until cleared |
| ol_mask | input | 1 | Leave open-load out of the no-error bit |
| raw_oc | input | NUM_DRV | Raw over-current comparator flags |
| raw_ol | input | NUM_DRV | Raw open-load comparator flags |
| raw_uv | input | 1 | Raw supply under-voltage flag |
| raw_ov | input | 1 | Raw supply over-voltage flag |
| raw_tw | input | 1 | Raw temperature-warning flag |
| raw_tsd | input | 1 | Raw thermal-shutdown flag |
| drv_off | output | NUM_DRV | Per-channel forced-off command |
| stat0 | output | 16 | Status word 0 |
| stat1 | output | 16 | Status word 1 |

## Verification
The tick phase is free-running, so each filter result can only be placed inside a window one tick wide. That window runs from (N-1)*TICK_DIV+2 to N*TICK_DIV+1 cycles after the raw edge, and the bench polls cycle by cycle and checks that the first set cycle falls inside it. Level effects are sampled on the falling edge after a fixed wait: channel release after a supply fault is due two cycles after the raw flag drops, and the effect of a clear or of en falling is due one cycle later. Retry duty is measured by counting on-cycles over 512 clocks. That span is a whole number of retry periods, so the count can be compared to its expected value with a small tolerance.

// File: rtl/fs_pkg.sv
package fs_pkg;
    // Off-time multipliers of the filter time for the two retry duties.
    localparam int RETRY_SHORT_MULT = 3;
    localparam int RETRY_LONG_MULT  = 7;
    localparam int STAT_W           = 16;

    typedef enum logic {
        DUTY_QUARTER = 1'b0,
        DUTY_EIGHTH  = 1'b1
    } duty_e;
endpackage

// File: rtl/fs_tick_gen.sv
module fs_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/fs_filter.sv
module fs_filter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic raw,
    output logic held
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] FULL = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || !raw)              cnt_d = '0;
        else if (tick && cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign held = (cnt_q == FULL);
endmodule

// File: rtl/fs_retry.sv
module fs_retry
    import fs_pkg::*;
#(
    parameter int FAST = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  tick,
    input  logic  trip,
    input  duty_e duty,
    output logic  off_active
);
    localparam int OFF_LONG  = RETRY_LONG_MULT * FAST;
    localparam int OFF_SHORT = RETRY_SHORT_MULT * FAST;
    localparam int CW        = $clog2(OFF_LONG + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)                        cnt_d = '0;
        else if (trip)                  cnt_d = (duty == DUTY_EIGHTH) ? CW'(OFF_LONG) : CW'(OFF_SHORT);
        else if (tick && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign off_active = (cnt_q != '0);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fs_pkg::*;
#(
    parameter int NUM_DRV       = 5,
    parameter int TICK_DIV      = 100,
    parameter int FAST_TICKS    = 32,
    parameter int OL_TICKS      = 1000,
    parameter int STARTUP_TICKS = 300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               clr_stat,
    input  logic [NUM_DRV-1:0] rec_en,
    input  logic               duty_hi,
    input  logic               uv_ov_latch,
    input  logic               ol_mask,
    input  logic [NUM_DRV-1:0] raw_oc,
    input  logic [NUM_DRV-1:0] raw_ol,
    input  logic               raw_uv,
    input  logic               raw_ov,
    input  logic               raw_tw,
    input  logic               raw_tsd,
    output logic [NUM_DRV-1:0] drv_off,
    output logic [STAT_W-1:0]  stat0,
    output logic [STAT_W-1:0]  stat1
);
    localparam int SW      = $clog2(STARTUP_TICKS + 1);
    localparam int UV_BIT  = NUM_DRV + 1;
    localparam int OV_BIT  = NUM_DRV + 2;
    localparam int TW_BIT  = NUM_DRV + 3;
    localparam int TSD_BIT = NUM_DRV + 4;
    localparam int NRDY_BIT = STAT_W - 1;
    localparam logic [SW-1:0] BOOT_DONE = SW'(STARTUP_TICKS);

    typedef struct packed {
        logic [NUM_DRV-1:0] oc;
        logic [NUM_DRV-1:0] ol;
        logic               uv;
        logic               ov;
        logic               tw;
        logic               tsd;
        logic [SW-1:0]      boot;
    } state_t;

    state_t st_d, st_q;

    logic               tick;
    logic [NUM_DRV-1:0] oc_held, ol_held, off_active, oc_inhibit, oc_raw_on;
    logic               uv_held, ov_held, tw_held, tsd_held;
    logic               not_ready, supply_off, no_err, all_off;
    duty_e              duty_sel;

    fs_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
    );

    // Over-current only counts while its channel actually conducts.
    assign oc_raw_on = raw_oc & ~drv_off;
    assign duty_sel  = (!duty_hi || st_q.tw) ? DUTY_EIGHTH : DUTY_QUARTER;

    for (genvar i = 0; i < NUM_DRV; i++) begin : g_chan
        fs_filter #(.LIMIT(FAST_TICKS)) u_oc_flt (
            .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
            .raw(oc_raw_on[i]), .held(oc_held[i])
        );
        fs_filter #(.LIMIT(OL_TICKS)) u_ol_flt (
            .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
            .raw(raw_ol[i]), .held(ol_held[i])
        );
        fs_retry #(.FAST(FAST_TICKS)) u_retry (
            .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
            .trip(oc_held[i]), .duty(duty_sel), .off_active(off_active[i])
        );
        assign oc_inhibit[i] = st_q.oc[i] && (!rec_en[i] || off_active[i]);
    end

    fs_filter #(.LIMIT(FAST_TICKS)) u_uv_flt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .raw(raw_uv), .held(uv_held)
    );
    fs_filter #(.LIMIT(FAST_TICKS)) u_ov_flt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .raw(raw_ov), .held(ov_held)
    );
    fs_filter #(.LIMIT(FAST_TICKS)) u_tw_flt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .raw(raw_tw), .held(tw_held)
    );
    fs_filter #(.LIMIT(FAST_TICKS)) u_tsd_flt (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .raw(raw_tsd), .held(tsd_held)
    );

    // Next state: a held condition sets its bit even in a clearing cycle.
    always_comb begin
        st_d     = st_q;
        st_d.oc  = (st_q.oc & {NUM_DRV{~clr_stat}}) | oc_held;
        st_d.ol  = (st_q.ol & {NUM_DRV{~clr_stat}}) | ol_held;
        st_d.uv  = (st_q.uv  & ~clr_stat) | uv_held;
        st_d.ov  = (st_q.ov  & ~clr_stat) | ov_held;
        st_d.tw  = (st_q.tw  & ~clr_stat) | tw_held;
        st_d.tsd = (st_q.tsd & ~clr_stat) | tsd_held;
        if (tick && st_q.boot != BOOT_DONE) st_d.boot = st_q.boot + 1'b1;
        if (!en) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign not_ready  = (st_q.boot != BOOT_DONE);
    assign supply_off = uv_held || ov_held || (uv_ov_latch && (st_q.uv || st_q.ov));
    assign all_off    = !en || not_ready || st_q.tsd || supply_off;
    assign drv_off    = oc_inhibit | {NUM_DRV{all_off}};

    assign no_err = !((|st_q.oc) || st_q.uv || st_q.ov || st_q.tw || st_q.tsd ||
                      ((|st_q.ol) && !ol_mask));

    always_comb begin
        stat0              = '0;
        stat0[0]           = no_err;
        stat0[NUM_DRV:1]   = st_q.oc;
        stat0[UV_BIT]      = st_q.uv;
        stat0[OV_BIT]      = st_q.ov;
        stat0[TW_BIT]      = st_q.tw;
        stat0[TSD_BIT]     = st_q.tsd;
        stat0[NRDY_BIT]    = not_ready;
        stat1              = '0;
        stat1[0]           = no_err;
        stat1[NUM_DRV:1]   = st_q.ol;
    end
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
    parameter int NUM_DRV = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               clr_stat,
    input logic               uv_ov_latch,
    input logic               ol_mask,
    input logic [NUM_DRV-1:0] rec_en,
    input logic [NUM_DRV-1:0] drv_off,
    input logic [15:0]        stat0,
    input logic [15:0]        stat1
);
    localparam int UV_BIT  = NUM_DRV + 1;
    localparam int OV_BIT  = NUM_DRV + 2;
    localparam int TSD_BIT = NUM_DRV + 4;

    AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (stat0 == 16'h8001 && stat1 == 16'h0001)); // R12

    AST_TSD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stat0[TSD_BIT] |-> (&drv_off)); // R7

    AST_NRDY_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stat0[15] |-> (&drv_off)); // R11

    AST_NOERR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stat0[14:1]) || ((|stat1[14:1]) && !ol_mask)) |-> (!stat0[0] && !stat1[0])); // R10

    AST_LATCHED_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_ov_latch && (stat0[UV_BIT] || stat0[OV_BIT])) |-> (&drv_off)); // R8

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr_stat) |=> ((stat0[14:1] & $past(stat0[14:1])) == $past(stat0[14:1]) &&
                               (stat1[14:1] & $past(stat1[14:1])) == $past(stat1[14:1]))); // R13

    for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
        AST_NOREC_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (stat0[i+1] && !rec_en[i]) |-> drv_off[i]); // R4
    end
endmodule

bind fault_supervisor fault_supervisor_chk #(.NUM_DRV(NUM_DRV)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .clr_stat(clr_stat),
    .uv_ov_latch(uv_ov_latch), .ol_mask(ol_mask), .rec_en(rec_en),
    .drv_off(drv_off), .stat0(stat0), .stat1(stat1)
);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
    localparam int N  = 5;
    localparam int TD = 4;
    localparam int FT = 4;
    localparam int OT = 10;
    localparam int ST = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0, en = 1'b0, clr_stat = 1'b0;
    logic [N-1:0] rec_en = '0, raw_oc = '0, raw_ol = '0;
    logic duty_hi = 1'b0, uv_ov_latch = 1'b0, ol_mask = 1'b0;
    logic raw_uv = 1'b0, raw_ov = 1'b0, raw_tw = 1'b0, raw_tsd = 1'b0;
    logic [N-1:0] drv_off;
    logic [15:0]  stat0, stat1;
    logic [31:0]  obs;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign obs = {stat1, stat0};

    fault_supervisor #(.NUM_DRV(N), .TICK_DIV(TD), .FAST_TICKS(FT), .OL_TICKS(OT),
                       .STARTUP_TICKS(ST)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .clr_stat(clr_stat), .rec_en(rec_en),
        .duty_hi(duty_hi), .uv_ov_latch(uv_ov_latch), .ol_mask(ol_mask),
        .raw_oc(raw_oc), .raw_ol(raw_ol), .raw_uv(raw_uv), .raw_ov(raw_ov),
        .raw_tw(raw_tw), .raw_tsd(raw_tsd), .drv_off(drv_off), .stat0(stat0), .stat1(stat1)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_val(input int idx, input logic val, input int lim, output int k);
        k = 0;
        while (obs[idx] !== val && k < lim) begin
            step(1);
            k++;
        end
    endtask

    task automatic pulse_clr();
        clr_stat = 1'b1;
        step(1);
        clr_stat = 1'b0;
    endtask

    task automatic count_on(input int ch, output int on);
        on = 0;
        for (int c = 0; c < 512; c++) begin
            step(1);
            if (!drv_off[ch]) on++;
        end
    endtask

    function automatic int fast_lo(input int t);
        return (t - 1) * TD + 2;
    endfunction

    function automatic int fast_hi(input int t);
        return t * TD + 1;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int k, on;
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1'b1;
        step(2);
        // R12: standby state
        check("R12 stat0 standby", {16'h0, stat0}, 32'h8001);
        check("R12 stat1 standby", {16'h0, stat1}, 32'h0001);
        check("R12 drv_off standby", {27'h0, drv_off}, 32'h1f);

        // R11: start-up
        en = 1'b1;
        step(1);
        check("R11 not-ready after en", {31'h0, stat0[15]}, 1);
        check("R11 outputs off at start", {27'h0, drv_off}, 32'h1f);
        wait_val(15, 1'b0, 100, k);
        check_rng("R11 not-ready window", k + 1, (ST - 1) * TD + 1, ST * TD);
        check("R11 outputs on after start", {27'h0, drv_off}, 0);

        // R3: random short glitches must never latch
        for (int it = 0; it < 24; it++) begin
            int sel, len;
            sel = $urandom_range(0, 13);
            len = $urandom_range(1, (FT - 2) * TD);
            if (sel < 5)       raw_oc[sel] = 1'b1;
            else if (sel < 10) raw_ol[sel-5] = 1'b1;
            else if (sel == 10) raw_uv = 1'b1;
            else if (sel == 11) raw_ov = 1'b1;
            else if (sel == 12) raw_tw = 1'b1;
            else               raw_tsd = 1'b1;
            step(len);
            raw_oc = '0; raw_ol = '0; raw_uv = 0; raw_ov = 0; raw_tw = 0; raw_tsd = 0;
            step(2);
            check("R3 glitch leaves status clear", {stat1[14:1], stat0[14:1]}, 0);
        end

        // R1/R4: over-current filter time and latch without retry
        raw_oc[0] = 1'b1;
        wait_val(1, 1'b1, 60, k);
        check_rng("R1 over-current filter window", k, fast_lo(FT), fast_hi(FT));
        check("R4 channel 0 off, others on", {27'h0, drv_off}, 32'h01);
        raw_oc[0] = 1'b0;
        step(30);
        check("R4 stays off without retry", {31'h0, drv_off[0]}, 1);
        pulse_clr();
        check("R4 clear releases channel", {27'h0, drv_off}, 0);
        check("R10 no-error after clear", {31'h0, stat0[0]}, 1);

        // R5: retry at quarter duty
        rec_en = 5'b00010;
        duty_hi = 1'b1;
        raw_oc[1] = 1'b1;
        wait_val(2, 1'b1, 60, k);
        step(16);
        count_on(1, on);
        check_rng("R5 quarter duty on-cycles", on, 116, 140);
        check("R5 status held during retry", {31'h0, stat0[2]}, 1);
        check("R5 other channels on", {27'h0, drv_off & 5'b11101}, 0);

        // R6: temperature warning forces eighth duty
        raw_tw = 1'b1;
        step(20);
        check("R6 warning latched", {31'h0, stat0[8]}, 1);
        step(200);
        count_on(1, on);
        check_rng("R6 warning forces long pause", on, 52, 76);
        raw_tw = 1'b0;

        // R5: eighth duty selected directly
        duty_hi = 1'b0;
        step(2);
        pulse_clr();
        step(200);
        count_on(1, on);
        check_rng("R5 eighth duty on-cycles", on, 52, 76);

        // R4: retry withdrawn keeps channel off
        rec_en = '0;
        step(100);
        check("R4 retry off keeps channel off", {31'h0, drv_off[1]}, 1);
        raw_oc[1] = 1'b0;
        step(50);
        check("R4 still off after raw drops", {31'h0, drv_off[1]}, 1);
        pulse_clr();
        check("R4 cleared channel 1 on", {27'h0, drv_off}, 0);

        // R7: thermal shutdown
        raw_tsd = 1'b1;
        wait_val(9, 1'b1, 60, k);
        check_rng("R1 thermal filter window", k, fast_lo(FT), fast_hi(FT));
        check("R7 all off on shutdown", {27'h0, drv_off}, 32'h1f);
        pulse_clr();
        check("R7 clear refused while hot", {31'h0, stat0[9]}, 1);
        raw_tsd = 1'b0;
        step(3);
        check("R7 still off after cooling", {27'h0, drv_off}, 32'h1f);
        pulse_clr();
        check("R7 clear accepted when cool", {31'h0, stat0[9]}, 0);
        check("R7 channels back", {27'h0, drv_off}, 0);

        // R13: fault still present at clear keeps its bit
        raw_tw = 1'b1;
        step(20);
        pulse_clr();
        check("R13 held warning survives clear", {31'h0, stat0[8]}, 1);
        check("R9 warning leaves channels on", {27'h0, drv_off}, 0);
        raw_tw = 1'b0;
        step(2);
        pulse_clr();
        check("R13 warning cleared once gone", {31'h0, stat0[8]}, 0);

        // R8: under-voltage with automatic return
        uv_ov_latch = 1'b0;
        raw_uv = 1'b1;
        step(20);
        check("R8 under-voltage all off", {27'h0, drv_off}, 32'h1f);
        check("R8 under-voltage latched", {31'h0, stat0[6]}, 1);
        raw_uv = 1'b0;
        step(2);
        check("R8 auto return", {27'h0, drv_off}, 0);
        check("R8 bit kept until clear", {31'h0, stat0[6]}, 1);
        pulse_clr();

        // R8: over-voltage with latched return
        uv_ov_latch = 1'b1;
        raw_ov = 1'b1;
        step(20);
        check("R8 over-voltage latched", {31'h0, stat0[7]}, 1);
        raw_ov = 1'b0;
        step(10);
        check("R8 latched mode stays off", {27'h0, drv_off}, 32'h1f);
        pulse_clr();
        check("R8 clear releases", {27'h0, drv_off}, 0);
        uv_ov_latch = 1'b0;

        // R2/R9/R10: open-load
        raw_ol[3] = 1'b1;
        wait_val(20, 1'b1, 80, k);
        check_rng("R2 open-load filter window", k, fast_lo(OT), fast_hi(OT));
        check("R9 open-load leaves channels on", {27'h0, drv_off}, 0);
        check("R10 open-load clears no-error", {31'h0, stat0[0]}, 0);
        ol_mask = 1'b1;
        step(1);
        check("R10 masked open-load", {31'h0, stat1[0]}, 1);
        ol_mask = 1'b0;
        raw_ol[3] = 1'b0;
        step(2);
        pulse_clr();
        check("R10 clean stat0", {16'h0, stat0}, 32'h0001);
        check("R10 clean stat1", {16'h0, stat1}, 32'h0001);

        // R12: en low clears latched state
        raw_tw = 1'b1;
        step(20);
        en = 1'b0;
        step(1);
        check("R12 stat0 after en low", {16'h0, stat0}, 32'h8001);
        check("R12 stat1 after en low", {16'h0, stat1}, 32'h0001);
        check("R12 outputs off", {27'h0, drv_off}, 32'h1f);
        raw_tw = 1'b0;
        en = 1'b1;
        step(1);
        check("R11 not-ready on re-enable", {31'h0, stat0[15]}, 1);
        step(ST * TD + 2);
        check("R11 ready again", {31'h0, stat0[15]}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule